// File: doc/BRIEF.md
# System Error Reporting Aggregator

This block gathers one-cycle error strobes from the subsystems of a bus bridge and turns them into a single active-low system error line. The line is meant to be wired open-drain style. The sources are:

- correctable and uncorrectable memory ECC errors;
- a target abort on a cycle the bridge itself started, on either the primary bus or the graphics port;
- an address-phase or data-phase parity error on either bus;
- a hit on an invalid entry in the graphics translation table;
- two kinds of illegal graphics master access:
  - one that falls outside the aperture;
  - one that falls outside both the aperture and main memory.

An event is passed on only when both gating levels allow it. The first level is a global enable bit taken from the command register. The second level is one enable bit per source, taken from the error command register. ECC events are also dropped while memory initialization is in progress. Each qualifying event pulls the output low for exactly one clock. It also sets a sticky status bit for its source. Software clears status bits by writing ones to a small write port.

Top module: `sys_err_collector`

## Requirements
- R1: When `glob_en` is 0, no event drives `serr_n` low or sets any bit of `status`.
- R2: A correctable ECC strobe on `evt[0]` and an uncorrectable ECC strobe on `evt[1]` each qualify only when the matching bit of `src_en` is 1 and `glob_en` is 1.
- R3: While `init_busy` is 1, strobes on `evt[0]` and `evt[1]` are ignored: the output stays high and status is unchanged. All other sources still qualify during initialization.
- R4: A target abort on a bridge-started cycle is reported on `evt[2]` for the primary bus and on `evt[3]` for the graphics port. Each is gated by its `src_en` bit.
- R5: An address or data parity error is reported on `evt[4]` for the primary bus and on `evt[5]` for the graphics port. These are separately enabled sources.
- R6: Three graphics sources are enabled independently of one another. `evt[6]` is an invalid translation table entry. `evt[7]` is an access outside the aperture. `evt[8]` is an access outside both the aperture and main memory.
- R7: A qualifying event sampled at one rising edge drives `serr_n` low for exactly the following clock cycle. Qualifying events on consecutive cycles produce back-to-back low cycles.
- R8: Several sources qualifying in the same cycle produce one single-clock low pulse, and every one of their status bits is set.
- R9: `status[i]` becomes 1 in the cycle after source i qualifies and holds until software clears it. A write with `wr_en`=1 clears each status bit whose `wr_data` bit is 1 and leaves bits written with 0 unchanged. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: After reset, `status` is all zeros and `serr_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 9 | One-cycle error strobes, one bit per source |
| glob_en | input | 1 | Global system error enable |
| src_en | input | 9 | Per-source enable bits |
| init_busy | input | 1 | Memory initialization in progress |
| wr_en | input | 1 | Status clear write strobe |
| wr_data | input | 9 | Write-one-to-clear mask for status |
| status | output | 9 | Sticky per-source status flags |
| serr_n | output | 1 | Active-low system error pulse |

## Verification
A status clear write and a fresh event on the same source can fall in the same cycle. The bench provokes this by raising `wr_en` with a mask covering a set bit while the same source strobes. It judges the result by requiring that bit to read 1 afterwards, alongside a low output cycle. A partial clear mask in the same stimulus shows that bits written with 0 survive and that other masked bits are cleared.

// File: rtl/sys_err_collector.sv
module sys_err_collector #(
  parameter int NSRC = 9,
  parameter int NECC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            glob_en,
  input  logic [NSRC-1:0] src_en,
  input  logic            init_busy,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] status,
  output logic            serr_n
);

  localparam logic [NSRC-1:0] ECC_MASK = NSRC'((1 << NECC) - 1);

  logic [NSRC-1:0] init_mask;
  logic [NSRC-1:0] qual;
  logic [NSRC-1:0] clr;

  assign init_mask = init_busy ? ~ECC_MASK : '1;
  assign qual      = evt & src_en & init_mask & {NSRC{glob_en}};
  assign clr       = wr_en ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      serr_n <= 1'b1;
    end else begin
      status <= (status & ~clr) | qual;
      serr_n <= ~|qual;
    end
  end

endmodule

module sys_err_collector_chk #(
  parameter int NSRC = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt,
  input logic            glob_en,
  input logic [NSRC-1:0] src_en,
  input logic            init_busy,
  input logic            wr_en,
  input logic [NSRC-1:0] status,
  input logic            serr_n
);

  assert_no_err_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> serr_n);

  assert_ecc_quiet_in_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && !(|evt[NSRC-1:2])) |=> serr_n);

  assert_primary_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && src_en[2] && evt[2]) |=> (!serr_n && status[2]));

  assert_single_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!serr_n && !(|evt)) |=> serr_n);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status & $past(status)) == $past(status)));

endmodule

bind sys_err_collector sys_err_collector_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .glob_en(glob_en), .src_en(src_en),
  .init_busy(init_busy), .wr_en(wr_en), .status(status), .serr_n(serr_n)
);

// File: tb/sys_err_collector_bench.sv
`timescale 1ns/1ps
module sys_err_collector_bench;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt;
  logic         glob_en;
  logic [N-1:0] src_en;
  logic         init_busy;
  logic         wr_en;
  logic [N-1:0] wr_data;
  logic [N-1:0] status;
  logic         serr_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sys_err_collector u_sys_err_collector (
    .clk(clk), .rst_n(rst_n), .evt(evt), .glob_en(glob_en), .src_en(src_en),
    .init_busy(init_busy), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .serr_n(serr_n)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    evt = '0; wr_en = 1'b1; wr_data = '1;
    @(negedge clk);
    idle();
  endtask

  function automatic string tag(input int i);
    if (i < 2) return "R2";
    if (i < 4) return "R4";
    if (i < 6) return "R5";
    return "R6";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; glob_en = 1'b0; src_en = '0; init_busy = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    chk("R10", status, '0);
    chk("R10", N'(serr_n), N'(1));
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      for (int g = 0; g < 2; g++) begin
        for (int m = 0; m < 3; m++) begin
          for (int b = 0; b < 2; b++) begin
            logic [N-1:0] en;
            logic q;
            en = (m == 0) ? '1 : (m == 1) ? N'(1) << i : ~(N'(1) << i);
            q  = (g == 1) && en[i] && !(b == 1 && i < 2);
            @(negedge clk);
            glob_en = g[0]; src_en = en; init_busy = b[0];
            evt = N'(1) << i;
            @(negedge clk);
            idle();
            chk(g == 0 ? "R1" : (b == 1 && i < 2) ? "R3" : tag(i), status, q ? N'(1) << i : '0);
            chk("R7", N'(serr_n), N'(!q));
            @(negedge clk);
            chk("R7", N'(serr_n), N'(1));
            clear_all();
          end
        end
      end
    end

    glob_en = 1'b1; src_en = '1; init_busy = 1'b0;
    @(negedge clk);
    evt = 9'h0A5;
    @(negedge clk);
    idle();
    chk("R8", status, 9'h0A5);
    chk("R8", N'(serr_n), N'(0));
    @(negedge clk);
    chk("R8", N'(serr_n), N'(1));
    clear_all();

    @(negedge clk);
    evt = 9'h004;
    @(negedge clk);
    evt = 9'h008;
    chk("R7", N'(serr_n), N'(0));
    @(negedge clk);
    idle();
    chk("R7", N'(serr_n), N'(0));
    chk("R7", status, 9'h00C);
    @(negedge clk);
    chk("R7", N'(serr_n), N'(1));
    clear_all();

    init_busy = 1'b1;
    @(negedge clk);
    evt = 9'h103;
    @(negedge clk);
    idle();
    chk("R3", status, 9'h100);
    init_busy = 1'b0;
    clear_all();

    @(negedge clk);
    evt = 9'h0F0;
    @(negedge clk);
    idle();
    wr_en = 1'b1; wr_data = 9'h030; evt = 9'h010;
    @(negedge clk);
    idle();
    chk("R9", status, 9'h0D0);
    chk("R9", N'(serr_n), N'(0));
    repeat (3) @(negedge clk);
    chk("R9", status, 9'h0D0);
    wr_en = 1'b1; wr_data = 9'h000;
    @(negedge clk);
    idle();
    chk("R9", status, 9'h0D0);
    clear_all();
    chk("R9", status, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule